// File: doc/BRIEF.md
# Sequential Accumulator Multiply/Divide Unit

This block performs multiply-accumulate and long division on three 16-bit accumulator operands, named here A0, A1 and A2. A single start strobe launches one of four operations, chosen by a 2-bit code. The block captures the operands and runs one shift-add or restoring-subtract step per cycle for 16 cycles. It then reports the new A0 and A1 values and a carry flag, together with a one-cycle done pulse.

A multiply forms A1×A2+A0 as a 32-bit value and returns it split into a high word (new A0) and a low word (new A1). A divide takes {A0,A1} as a 32-bit dividend and A2 as the divisor. It returns the quotient as the new A1 and the remainder as the new A0. A divide that cannot produce a valid 16-bit quotient sets carry and gives back the original A0 and A1 untouched. The surrounding core decodes the instruction and writes the results into its register file.

Signed operations remove the operand signs first and run the same unsigned step engine on the magnitudes. The signs are restored in a final cycle, and the signed quotient range is checked in that same cycle.

Top module: `acc_muldiv`

## Requirements
- R1: While reset is asserted and after it is released, busy_o, done_o, carry_o, ac0_o and ac1_o are all 0.
- R2: Op code 2'b00 (unsigned multiply) returns ac0_o:ac1_o = A1×A2+A0 as an unsigned 32-bit value, with ac0_o holding bits 31:16.
- R3: Op code 2'b01 (unsigned divide) with A0 < A2 returns quotient floor({A0,A1}/A2) on ac1_o, the remainder on ac0_o, and carry_o = 0.
- R4: Unsigned divide with A0 ≥ A2, including A2 = 0, returns carry_o = 1 with ac0_o = A0 and ac1_o = A1.
- R5: Op code 2'b10 (signed multiply) sign-extends all three operands and returns the low 32 bits of A1×A2+A0 as ac0_o (high word) and ac1_o (low word).
- R6: Op code 2'b11 (signed divide) with a nonzero divisor and an in-range quotient returns the quotient truncated toward zero on ac1_o, a remainder carrying the dividend's sign on ac0_o, and carry_o = 0.
- R7: Signed divide by zero returns carry_o = 1 with ac0_o = A0 and ac1_o = A1.
- R8: Signed divide whose quotient falls outside −32768..32767 returns carry_o = 1 with ac0_o = A0 and ac1_o = A1.
- R9: A start accepted at clock edge k raises busy_o after that edge. busy_o drops and done_o rises after edge k+17, so busy_o and done_o are never high together.
- R10: A start_i pulse while busy_o is high has no effect: the running operation completes with its own operands on schedule, and no extra done pulse follows.
- R11: Both multiplies return on carry_o the carry_i value that was sampled with the start.
- R12: done_o is high for exactly one cycle. ac0_o, ac1_o and carry_o keep their values until the next completion, whatever the operand inputs do in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launches an operation when the unit is idle |
| op_i | input | 2 | Operation: 00 umul, 01 udiv, 10 smul, 11 sdiv |
| ac0_i | input | 16 | A0 operand (addend or dividend high word) |
| ac1_i | input | 16 | A1 operand (multiplier or dividend low word) |
| ac2_i | input | 16 | A2 operand (multiplicand or divisor) |
| carry_i | input | 1 | Incoming carry, returned unchanged by multiplies |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse; results valid in this cycle |
| ac0_o | output | 16 | New A0: product high word or remainder |
| ac1_o | output | 16 | New A1: product low word or quotient |
| carry_o | output | 1 | Divide error flag, or the passed-through carry for a multiply |

## Verification
The assertions assume that the operands, op code and carry input matter only in the cycle where start_i is accepted. The block captures them in that cycle, and later changes must not reach the results. The stimulus holds start_i for exactly one cycle. It changes the operand inputs freely while busy and while idle, so both the capture and the ignore path are exercised. The divide remainder check assumes that an unsigned divide that passes the high-word pre-check keeps its partial remainder below the divisor. The bench reaches the boundary of that condition with A0 = A2−1 and A0 = A2.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic [1:0] {
    OP_UMUL = 2'b00,
    OP_UDIV = 2'b01,
    OP_SMUL = 2'b10,
    OP_SDIV = 2'b11
  } mdu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_FIX  = 2'b10
  } mdu_state_e;
endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
  import mdu_pkg::*;
#(
  parameter int ITER = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic load_o,
  output logic step_o,
  output logic finish_o
);
  localparam int CW = (ITER > 1) ? $clog2(ITER) : 1;
  localparam logic [CW-1:0] LAST = CW'(ITER - 1);

  mdu_state_e state_q;
  logic [CW-1:0] cnt_q;

  assign busy_o   = (state_q != ST_IDLE);
  assign load_o   = start_i && (state_q == ST_IDLE);
  assign step_o   = (state_q == ST_RUN);
  assign finish_o = (state_q == ST_FIX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) state_q <= ST_FIX;
        end
        ST_FIX:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_RUN_CONTINUES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o && (cnt_q != LAST) |=> step_o);  // R9
  AST_LAST_STEP_FIX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o && (cnt_q == LAST) |=> finish_o);  // R9
  AST_FIX_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finish_o |=> !busy_o);  // R9
endmodule

// File: rtl/mdu_mul_core.sv
module mdu_mul_core #(
  parameter int W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic [2*W-1:0] prod_o
);
  logic [W-1:0] mcand_q, hi_q, lo_q;
  logic [W:0]   sum;

  // add multiplicand when the multiplier lsb is set, then shift right
  assign sum    = {1'b0, hi_q} + (lo_q[0] ? {1'b0, mcand_q} : '0);
  assign prod_o = {hi_q, lo_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
    end else if (load_i) begin
      mcand_q <= mcand_i;
      hi_q    <= '0;
      lo_q    <= mplier_i;
    end else if (step_i) begin
      hi_q <= sum[W:1];
      lo_q <= {sum[0], lo_q[W-1:1]};
    end
  end

  AST_MCAND_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> $stable(mcand_q));  // R2
endmodule

// File: rtl/mdu_div_core.sv
module mdu_div_core #(
  parameter int W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [2*W-1:0] num_i,
  input  logic [W-1:0]   den_i,
  output logic [W-1:0]   quo_o,
  output logic [W-1:0]   rem_o,
  output logic           ovf_o
);
  logic [W-1:0] rem_q, quo_q, den_q;
  logic         ovf_q;
  logic [W:0]   trial, diff;
  logic         fits;

  assign trial = {rem_q, quo_q[W-1]};
  assign diff  = trial - {1'b0, den_q};
  assign fits  = (trial >= {1'b0, den_q});

  assign quo_o = quo_q;
  assign rem_o = rem_q;
  assign ovf_o = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      quo_q <= '0;
      den_q <= '0;
      ovf_q <= 1'b0;
    end else if (load_i) begin
      rem_q <= num_i[2*W-1:W];
      quo_q <= num_i[W-1:0];
      den_q <= den_i;
      // quotient needs more than W bits (covers a zero divisor)
      ovf_q <= (num_i[2*W-1:W] >= den_i);
    end else if (step_i) begin
      rem_q <= fits ? diff[W-1:0] : trial[W-1:0];
      quo_q <= {quo_q[W-2:0], fits};
    end
  end

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !ovf_q |=> rem_q < den_q);  // R3
endmodule

// File: rtl/acc_muldiv.sv
module acc_muldiv
  import mdu_pkg::*;
#(
  parameter int W    = 16,
  parameter int ITER = W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] ac0_i,
  input  logic [W-1:0] ac1_i,
  input  logic [W-1:0] ac2_i,
  input  logic         carry_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] ac0_o,
  output logic [W-1:0] ac1_o,
  output logic         carry_o
);
  localparam int DW = 2 * W;

  logic load, step, finish;
  logic [1:0]   op_q;
  logic [W-1:0] a0_q, a1_q, a2_q;
  logic         cin_q;

  mdu_ctrl #(.ITER(ITER)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .busy_o  (busy_o),
    .load_o  (load),
    .step_o  (step),
    .finish_o(finish)
  );

  // operand magnitudes at load time
  logic          sgn_in, n1, n2, n0;
  logic [W-1:0]  mag1, mag2;
  logic [DW-1:0] num_raw, num_mag;

  assign sgn_in  = op_i[1];
  assign n0      = sgn_in & ac0_i[W-1];
  assign n1      = sgn_in & ac1_i[W-1];
  assign n2      = sgn_in & ac2_i[W-1];
  assign mag1    = n1 ? (~ac1_i + 1'b1) : ac1_i;
  assign mag2    = n2 ? (~ac2_i + 1'b1) : ac2_i;
  assign num_raw = {ac0_i, ac1_i};
  assign num_mag = n0 ? (~num_raw + 1'b1) : num_raw;

  logic [DW-1:0] prod;
  logic [W-1:0]  quo_mag, rem_mag;
  logic          pre_ovf;

  mdu_mul_core #(.W(W)) u_mul (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .step_i  (step && !op_q[0]),
    .mcand_i (mag2),
    .mplier_i(mag1),
    .prod_o  (prod)
  );

  mdu_div_core #(.W(W)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .step_i(step && op_q[0]),
    .num_i (num_mag),
    .den_i (mag2),
    .quo_o (quo_mag),
    .rem_o (rem_mag),
    .ovf_o (pre_ovf)
  );

  // sign restore and range check in the final cycle
  logic          sgn_q, prod_neg, num_neg, quo_neg, post_ovf, div_err;
  logic [DW-1:0] prod_s, addend, mac;
  logic [W-1:0]  quo_s, rem_s;

  assign sgn_q    = op_q[1];
  assign prod_neg = sgn_q & (a1_q[W-1] ^ a2_q[W-1]);
  assign num_neg  = sgn_q & a0_q[W-1];
  assign quo_neg  = sgn_q & (a0_q[W-1] ^ a2_q[W-1]);
  assign prod_s   = prod_neg ? (~prod + 1'b1) : prod;
  assign addend   = {{W{sgn_q & a0_q[W-1]}}, a0_q};
  assign mac      = prod_s + addend;
  assign quo_s    = quo_neg ? (~quo_mag + 1'b1) : quo_mag;
  assign rem_s    = num_neg ? (~rem_mag + 1'b1) : rem_mag;
  // magnitude limit is 2^(W-1) for a negative quotient, 2^(W-1)-1 otherwise
  assign post_ovf = sgn_q & quo_mag[W-1] & (!quo_neg || (quo_mag[W-2:0] != '0));
  assign div_err  = pre_ovf | post_ovf;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= '0;
      a0_q    <= '0;
      a1_q    <= '0;
      a2_q    <= '0;
      cin_q   <= 1'b0;
      done_o  <= 1'b0;
      ac0_o   <= '0;
      ac1_o   <= '0;
      carry_o <= 1'b0;
    end else begin
      done_o <= finish;
      if (load) begin
        op_q  <= op_i;
        a0_q  <= ac0_i;
        a1_q  <= ac1_i;
        a2_q  <= ac2_i;
        cin_q <= carry_i;
      end
      if (finish) begin
        if (!op_q[0]) begin
          ac0_o   <= mac[DW-1:W];
          ac1_o   <= mac[W-1:0];
          carry_o <= cin_q;
        end else if (div_err) begin
          ac0_o   <= a0_q;
          ac1_o   <= a1_q;
          carry_o <= 1'b1;
        end else begin
          ac0_o   <= rem_s;
          ac1_o   <= quo_s;
          carry_o <= 1'b0;
        end
      end
    end
  end

  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);  // R9
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R12
  AST_BUSY_KEEPS_OPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(op_q) && $stable(a0_q) && $stable(a1_q) && $stable(a2_q));  // R10
  AST_DIV_ERR_KEEPS_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && op_q[0] && carry_o |-> (ac0_o == a0_q) && (ac1_o == a1_q));  // R4
  AST_UDIV_REM_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && (op_q == OP_UDIV) && !carry_o |-> ac0_o < a2_q);  // R3
  AST_MUL_CARRY_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !op_q[0] |-> carry_o == cin_q);  // R11
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !done_o |=> $stable(ac0_o) && $stable(ac1_o) && $stable(carry_o));  // R12
endmodule

// File: tb/acc_muldiv_tb.sv
module acc_muldiv_tb;
  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] a0;
    logic [15:0] a1;
    logic [15:0] a2;
    logic        cin;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 16'h0000, 16'h0003, 16'h0005, 1'b0},
    '{2'b00, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b1},
    '{2'b00, 16'h1234, 16'h0000, 16'h5678, 1'b0},
    '{2'b00, 16'h00FF, 16'hABCD, 16'h1357, 1'b1},
    '{2'b01, 16'h0000, 16'd100,  16'd7,    1'b0},
    '{2'b01, 16'h1234, 16'h5678, 16'hFFFF, 1'b1},
    '{2'b01, 16'h7FFF, 16'hFFFF, 16'h8000, 1'b0},
    '{2'b01, 16'h0004, 16'h0000, 16'h0005, 1'b0},
    '{2'b01, 16'h0005, 16'h0000, 16'h0005, 1'b0},
    '{2'b01, 16'h0000, 16'h0009, 16'h0000, 1'b0},
    '{2'b10, 16'h0000, 16'hFFFD, 16'h0005, 1'b0},
    '{2'b10, 16'hFFFF, 16'h8000, 16'h8000, 1'b0},
    '{2'b10, 16'd100,  16'hFFF9, 16'hFFF7, 1'b1},
    '{2'b10, 16'h8000, 16'h7FFF, 16'h8000, 1'b1},
    '{2'b11, 16'hFFFF, 16'hFFF9, 16'h0002, 1'b0},
    '{2'b11, 16'h0000, 16'h0007, 16'hFFFE, 1'b0},
    '{2'b11, 16'hFFFF, 16'h8000, 16'h0001, 1'b0},
    '{2'b11, 16'hFFFF, 16'h0000, 16'h0002, 1'b0},
    '{2'b11, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b0},
    '{2'b11, 16'h0000, 16'h0005, 16'h0000, 1'b1},
    '{2'b11, 16'h0000, 16'h8000, 16'h0001, 1'b0},
    '{2'b11, 16'h0001, 16'h0000, 16'h0001, 1'b0}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic [15:0] ac0_i = '0, ac1_i = '0, ac2_i = '0;
  logic        carry_i = 1'b0;
  logic        busy_o, done_o, carry_o;
  logic [15:0] ac0_o, ac1_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  acc_muldiv u_dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .op_i   (op_i),
    .ac0_i  (ac0_i),
    .ac1_i  (ac1_i),
    .ac2_i  (ac2_i),
    .carry_i(carry_i),
    .busy_o (busy_o),
    .done_o (done_o),
    .ac0_o  (ac0_o),
    .ac1_o  (ac1_o),
    .carry_o(carry_o)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // reference model written from the requirements
  task automatic model(input vec_t v, output logic [15:0] e0, output logic [15:0] e1,
                       output logic ec, output string tag);
    longint p, n, d, q, r;
    logic [31:0] w;
    e0 = v.a0; e1 = v.a1; ec = 1'b1; tag = "R4";
    case (v.op)
      2'b00: begin
        p = longint'(v.a1) * longint'(v.a2) + longint'(v.a0);
        w = p[31:0]; e0 = w[31:16]; e1 = w[15:0]; ec = v.cin; tag = "R2";
      end
      2'b01: begin
        if (v.a0 >= v.a2 || v.a2 == 16'h0) tag = "R4";
        else begin
          n = longint'({v.a0, v.a1}); d = longint'(v.a2);
          q = n / d; r = n % d;
          e1 = q[15:0]; e0 = r[15:0]; ec = 1'b0; tag = "R3";
        end
      end
      2'b10: begin
        p = longint'($signed(v.a1)) * longint'($signed(v.a2)) + longint'($signed(v.a0));
        w = p[31:0]; e0 = w[31:16]; e1 = w[15:0]; ec = v.cin; tag = "R5";
      end
      default: begin
        if (v.a2 == 16'h0) tag = "R7";
        else begin
          n = longint'($signed({v.a0, v.a1})); d = longint'($signed(v.a2));
          q = n / d; r = n % d;
          if (q > 32767 || q < -32768) tag = "R8";
          else begin
            e1 = q[15:0]; e0 = r[15:0]; ec = 1'b0; tag = "R6";
          end
        end
      end
    endcase
  endtask

  task automatic drive(input vec_t v);
    op_i = v.op; ac0_i = v.a0; ac1_i = v.a1; ac2_i = v.a2; carry_i = v.cin;
  endtask

  // start at a negedge, then count negedges until done is seen
  task automatic run_op(input vec_t v, input vec_t noise, input int noise_at,
                        output logic [15:0] r0, output logic [15:0] r1,
                        output logic rc, output int lat);
    @(negedge clk_i);
    drive(v); start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R9", "busy after start", 32'(busy_o), 32'd1);
    drive(noise);
    lat = 0;
    while (!done_o && lat < 40) begin
      @(negedge clk_i);
      lat++;
      if (lat == noise_at) start_i = 1'b1;
      else start_i = 1'b0;
    end
    start_i = 1'b0;
    r0 = ac0_o; r1 = ac1_o; rc = carry_o;
    chk("R9", "busy low at done", 32'(busy_o), 32'd0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] r0, r1, e0, e1;
    logic rc, ec;
    string tag;
    int lat;
    vec_t idle_v;
    idle_v = '{2'b10, 16'hDEAD, 16'hBEEF, 16'h0F0F, 1'b1};

    // R1 reset state
    repeat (3) @(negedge clk_i);
    chk("R1", "busy in reset", 32'(busy_o), 32'd0);
    chk("R1", "done in reset", 32'(done_o), 32'd0);
    chk("R1", "outputs in reset", {ac0_o, ac1_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "carry after reset", 32'(carry_o), 32'd0);
    chk("R1", "busy after reset", 32'(busy_o), 32'd0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      model(VECS[i], e0, e1, ec, tag);
      run_op(VECS[i], idle_v, 0, r0, r1, rc, lat);
      chk(tag, "ac0", 32'(r0), 32'(e0));
      chk(tag, "ac1", 32'(r1), 32'(e1));
      chk(tag, "carry", 32'(rc), 32'(ec));
      chk("R9", "latency", 32'(lat), 32'd17);
    end

    // R11 carry passthrough both polarities
    run_op('{2'b00, 16'h0001, 16'h0002, 16'h0003, 1'b1}, idle_v, 0, r0, r1, rc, lat);
    chk("R11", "umul carry set", 32'(rc), 32'd1);
    run_op('{2'b10, 16'h0001, 16'h0002, 16'h0003, 1'b0}, idle_v, 0, r0, r1, rc, lat);
    chk("R11", "smul carry clear", 32'(rc), 32'd0);

    // R10 start while busy is ignored
    model('{2'b01, 16'h0003, 16'h0010, 16'h0009, 1'b0}, e0, e1, ec, tag);
    run_op('{2'b01, 16'h0003, 16'h0010, 16'h0009, 1'b0},
           '{2'b00, 16'h7777, 16'h1111, 16'h2222, 1'b1}, 5, r0, r1, rc, lat);
    chk("R10", "ac0 unaffected", 32'(r0), 32'(e0));
    chk("R10", "ac1 unaffected", 32'(r1), 32'(e1));
    chk("R10", "carry unaffected", 32'(rc), 32'(ec));
    chk("R10", "latency unaffected", 32'(lat), 32'd17);

    // R12 done is one cycle, outputs hold while idle inputs move
    @(negedge clk_i);
    chk("R12", "done one cycle", 32'(done_o), 32'd0);
    drive('{2'b11, 16'hAAAA, 16'h5555, 16'h0001, 1'b1});
    begin
      int extra;
      extra = 0;
      for (int k = 0; k < 25; k++) begin
        @(negedge clk_i);
        if (done_o || busy_o) extra++;
      end
      chk("R10", "no extra operation", 32'(extra), 32'd0);
    end
    chk("R12", "ac0 held", 32'(ac0_o), 32'(e0));
    chk("R12", "ac1 held", 32'(ac1_o), 32'(e1));
    chk("R12", "carry held", 32'(carry_o), 32'(ec));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule